// File: doc/BRIEF.md
# NAND Flash Read Command Sequencer

This block runs one NAND flash operation each time software starts it. Software first loads two address registers and two destination base registers, then writes a control word. That word carries a start bit, an interrupt enable, a 5-bit address-byte select mask, an 8-bit opcode, a flag nibble and a 12-bit byte count. The sequencer then drives the flash pins through a fixed series of phases. It issues one command-latch cycle, then one address-latch cycle for each selected byte. If the wait flag is set, it waits for the ready/busy pin to fall and rise again. It then reads the counted number of bytes with read-enable pulses.

Each byte read is handed to one of two write ports. The first `MAIN_BYTES` bytes go to the main-data sink and the rest go to the spare/ECC sink. Each port adds the byte's offset within its own area to its base register. While the operation runs, bit 31 of the control word reads back as busy. When the operation ends, a sticky interrupt is raised if it was enabled.

The state machine has seven states. `S_IDLE` waits for a start. `S_CMD` is the command latch. `S_ADDR` holds one address latch per selected byte. `S_WAIT_LO` and `S_WAIT_HI` follow the ready/busy pin. `S_READ` makes one read pulse per byte. `S_DONE` is a one-cycle finish. The transitions are:
- S_IDLE to S_CMD on a start.
- S_CMD to S_ADDR when the mask is non-zero. Otherwise it goes to the post-address target.
- S_ADDR repeats until the last selected byte, then goes to the post-address target.
- The post-address target is S_WAIT_LO when the wait flag is set. Otherwise it is S_READ when the count is non-zero, and S_DONE when the count is zero.
- S_WAIT_LO to S_WAIT_HI when the synchronised ready/busy is low.
- S_WAIT_HI to S_READ or S_DONE when it is high again.
- S_READ to S_DONE after the last byte.
- S_DONE to S_IDLE.

Top module: `nand_seq_top`

## Requirements
- R1: After reset the pins are idle: command latch low, address latch low, write-enable high, read-enable high and data bus not driven. The busy bit reads 0 and `irq` is 0.
- R2: Register word 0 reads back as {busy[31], irq_en[30], 0[29], mask[28:24], opcode[23:16], flags[15:12], count[11:0]}. Words 1 to 4 read back the low address, high address, main base and spare base registers.
- R3: A write to word 0 with bit 31 set, made while idle, starts an operation. Busy reads 1 from the next cycle until the operation ends.
- R4: Each operation begins with exactly one command latch. In that latch the command-latch pin is high, the address-latch pin is low, write-enable is low for `WE_LOW_CYC` clocks, and the opcode is on the bus when write-enable rises.
- R5: One address latch follows for each set mask bit, in order from bit 4 down to bit 0. The byte for each bit is:
  - bit 4: low register [15:8]
  - bit 3: low register [7:0]
  - bit 2: high register [23:16]
  - bit 1: high register [15:8]
  - bit 0: high register [7:0]

  High register [31:24] is never sent.
- R6: When flag bit 15 is set, no read pulse occurs until the ready/busy input has been seen low and then high.
- R7: Exactly `count` bytes are read. Each read pulse holds read-enable low for `RE_LOW_CYC` clocks, and the bus is sampled as read-enable rises.
- R8: Byte k with k < `MAIN_BYTES` is written to the main sink at main_base+k. Any later byte is written to the spare sink at spare_base+(k-`MAIN_BYTES`). The two sinks are never written in the same cycle.
- R9: With a count of 0 there is no read pulse. The operation ends after the address phase, or after the wait when the wait flag is set.
- R10: A write to word 0 while busy changes neither the running operation nor the fields read back, and starts nothing.
- R11: With irq_en set, `irq` rises as the operation ends and stays high until the next write to word 0. With irq_en clear, `irq` stays low.
- R12: A write to word 0 with bit 31 clear updates the fields but starts no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register word index for writes |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register word index for reads |
| reg_rd_data | output | 32 | Register read data (combinational) |
| irq | output | 1 | Sticky completion interrupt |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_io_out | output | 8 | Bus value driven to flash |
| nand_io_oe | output | 1 | Bus output enable |
| nand_io_in | input | 8 | Bus value from flash |
| nand_rb_n | input | 1 | Ready/busy, low while flash is busy |
| main_wr_en | output | 1 | Main sink write strobe |
| main_wr_addr | output | AW | Main sink byte address |
| main_wr_data | output | 8 | Main sink byte |
| spare_wr_en | output | 1 | Spare sink write strobe |
| spare_wr_addr | output | AW | Spare sink byte address |
| spare_wr_data | output | 8 | Spare sink byte |

## Verification
The bench keeps the default `MAIN_BYTES` of 2048. This makes the real page split reachable: a full 0x840-byte read and random counts just around 0x800 both cross into the spare sink. It builds the block with `WE_LOW_CYC`=2, `WE_HIGH_CYC`=1, `RE_LOW_CYC`=2 and `RE_HIGH_CYC`=1. The short high phases make back-to-back latches and reads dense, while the two-cycle low phases still let pulse-width checks see a wrong width.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_ADDR,
        S_WAIT_LO,
        S_WAIT_HI,
        S_READ,
        S_DONE
    } seq_state_t;

    typedef struct packed {
        logic        irq_en;
        logic [4:0]  mask;
        logic [7:0]  opcode;
        logic [3:0]  flags;
        logic [11:0] count;
    } op_cfg_t;

    localparam logic [2:0] W_CTRL    = 3'd0;
    localparam logic [2:0] W_ADDR_LO = 3'd1;
    localparam logic [2:0] W_ADDR_HI = 3'd2;
    localparam logic [2:0] W_MAIN    = 3'd3;
    localparam logic [2:0] W_SPARE   = 3'd4;

    localparam int WAIT_FLAG_BIT = 3;

endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
    import nand_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [2:0]    rd_addr,
    output logic [31:0]   rd_data,
    input  logic          busy,
    input  logic          done,
    output op_cfg_t       cfg,
    output logic [31:0]   addr_lo,
    output logic [31:0]   addr_hi,
    output logic [AW-1:0] main_base,
    output logic [AW-1:0] spare_base,
    output logic          start,
    output logic          irq
);

    logic ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == W_CTRL);
    assign start   = ctrl_wr && wr_data[31] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg        <= '0;
            addr_lo    <= '0;
            addr_hi    <= '0;
            main_base  <= '0;
            spare_base <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                W_CTRL: begin
                    if (!busy) begin
                        cfg.irq_en <= wr_data[30];
                        cfg.mask   <= wr_data[28:24];
                        cfg.opcode <= wr_data[23:16];
                        cfg.flags  <= wr_data[15:12];
                        cfg.count  <= wr_data[11:0];
                    end
                end
                W_ADDR_LO: addr_lo    <= wr_data;
                W_ADDR_HI: addr_hi    <= wr_data;
                W_MAIN:    main_base  <= wr_data[AW-1:0];
                W_SPARE:   spare_base <= wr_data[AW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (done && cfg.irq_en) begin
            irq <= 1'b1;
        end else if (ctrl_wr) begin
            irq <= 1'b0;
        end
    end

    always_comb begin
        unique case (rd_addr)
            W_CTRL:    rd_data = {busy, cfg.irq_en, 1'b0, cfg.mask, cfg.opcode,
                                  cfg.flags, cfg.count};
            W_ADDR_LO: rd_data = addr_lo;
            W_ADDR_HI: rd_data = addr_hi;
            W_MAIN:    rd_data = 32'(main_base);
            W_SPARE:   rd_data = 32'(spare_base);
            default:   rd_data = '0;
        endcase
    end

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg)); // R10
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ctrl_wr) |=> irq); // R11
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> cfg.irq_en); // R11

endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int WE_LOW_CYC  = 2,
    parameter int WE_HIGH_CYC = 1,
    parameter int RE_LOW_CYC  = 2,
    parameter int RE_HIGH_CYC = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  op_cfg_t     cfg,
    input  logic [31:0] addr_lo,
    input  logic [31:0] addr_hi,
    input  logic        rb_n,
    input  logic [7:0]  io_in,
    output logic        cle,
    output logic        ale,
    output logic        we_n,
    output logic        re_n,
    output logic [7:0]  io_out,
    output logic        io_oe,
    output logic        busy,
    output logic        done,
    output logic        cap_valid,
    output logic [11:0] cap_idx,
    output logic [7:0]  cap_data
);

    localparam int LATCH_LEN = WE_LOW_CYC + WE_HIGH_CYC;
    localparam int READ_LEN  = RE_LOW_CYC + RE_HIGH_CYC;
    localparam int BEAT_MAX  = (LATCH_LEN > READ_LEN) ? LATCH_LEN : READ_LEN;
    localparam int BEAT_W    = $clog2(BEAT_MAX + 1);

    seq_state_t        state, state_nx, post_addr;
    logic [BEAT_W-1:0] beat;
    logic [4:0]        pend, pend_nx;
    logic [2:0]        cur_bit;
    logic [7:0]        cur_byte;
    logic [11:0]       byte_idx;
    logic [1:0]        rb_sync;
    logic              latch_end, read_cap, read_end, last_byte;

    function automatic logic [2:0] top_bit(input logic [4:0] m);
        logic [2:0] r;
        r = 3'd0;
        for (int i = 0; i < 5; i++) begin
            if (m[i]) r = 3'(i);
        end
        return r;
    endfunction

    always_comb begin
        cur_bit = top_bit(pend);
        pend_nx = pend & ~(5'b00001 << cur_bit);
        unique case (cur_bit)
            3'd4:    cur_byte = addr_lo[15:8];
            3'd3:    cur_byte = addr_lo[7:0];
            3'd2:    cur_byte = addr_hi[23:16];
            3'd1:    cur_byte = addr_hi[15:8];
            default: cur_byte = addr_hi[7:0];
        endcase
    end

    assign latch_end = (beat == BEAT_W'(LATCH_LEN - 1));
    assign read_cap  = (beat == BEAT_W'(RE_LOW_CYC - 1));
    assign read_end  = (beat == BEAT_W'(READ_LEN - 1));
    assign last_byte = (byte_idx == cfg.count - 12'd1);

    always_comb begin
        if (cfg.flags[WAIT_FLAG_BIT])  post_addr = S_WAIT_LO;
        else if (cfg.count != 12'd0)   post_addr = S_READ;
        else                           post_addr = S_DONE;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_CMD;
            S_CMD:     if (latch_end) state_nx = (cfg.mask != 5'd0) ? S_ADDR : post_addr;
            S_ADDR:    if (latch_end && pend_nx == 5'd0) state_nx = post_addr;
            S_WAIT_LO: if (!rb_sync[1]) state_nx = S_WAIT_HI;
            S_WAIT_HI: if (rb_sync[1]) state_nx = (cfg.count != 12'd0) ? S_READ : S_DONE;
            S_READ:    if (read_end && last_byte) state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            beat      <= '0;
            pend      <= '0;
            byte_idx  <= '0;
            rb_sync   <= 2'b11;
            cap_valid <= 1'b0;
            cap_idx   <= '0;
            cap_data  <= '0;
        end else begin
            state     <= state_nx;
            rb_sync   <= {rb_sync[0], rb_n};
            cap_valid <= 1'b0;
            if (state_nx != state) begin
                beat <= '0;
            end else if ((state == S_CMD || state == S_ADDR) && !latch_end) begin
                beat <= beat + 1'b1;
            end else if (state == S_READ && !read_end) begin
                beat <= beat + 1'b1;
            end else begin
                beat <= '0;
            end
            if (state == S_CMD && latch_end) begin
                pend <= cfg.mask;
            end else if (state == S_ADDR && latch_end) begin
                pend <= pend_nx;
            end
            if (state != S_READ) begin
                byte_idx <= '0;
            end else begin
                if (read_cap) begin
                    cap_valid <= 1'b1;
                    cap_idx   <= byte_idx;
                    cap_data  <= io_in;
                end
                if (read_end && !last_byte) byte_idx <= byte_idx + 12'd1;
            end
        end
    end

    // pin outputs
    always_comb begin
        cle    = 1'b0;
        ale    = 1'b0;
        we_n   = 1'b1;
        re_n   = 1'b1;
        io_out = 8'h00;
        io_oe  = 1'b0;
        unique case (state)
            S_CMD: begin
                cle    = 1'b1;
                io_oe  = 1'b1;
                io_out = cfg.opcode;
                we_n   = !(beat < BEAT_W'(WE_LOW_CYC));
            end
            S_ADDR: begin
                ale    = 1'b1;
                io_oe  = 1'b1;
                io_out = cur_byte;
                we_n   = !(beat < BEAT_W'(WE_LOW_CYC));
            end
            S_READ: re_n = !(beat < BEAT_W'(RE_LOW_CYC));
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale)); // R4
    AST_LATCH_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((cle || ale) && !we_n && $past(!we_n)) |-> $stable(io_out)); // R5
    AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> (!cle && !ale && !io_oe)); // R7
    AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_READ) |-> (cfg.count != 12'd0)); // R9

endmodule

// File: rtl/nand_seq_router.sv
module nand_seq_router #(
    parameter int MAIN_BYTES = 2048,
    parameter int AW         = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_valid,
    input  logic [11:0]   cap_idx,
    input  logic [7:0]    cap_data,
    input  logic [AW-1:0] main_base,
    input  logic [AW-1:0] spare_base,
    output logic          main_wr_en,
    output logic [AW-1:0] main_wr_addr,
    output logic [7:0]    main_wr_data,
    output logic          spare_wr_en,
    output logic [AW-1:0] spare_wr_addr,
    output logic [7:0]    spare_wr_data
);

    localparam logic [12:0] SPLIT = 13'(MAIN_BYTES);

    logic        in_main;
    logic [11:0] spare_off;

    assign in_main   = {1'b0, cap_idx} < SPLIT;
    assign spare_off = cap_idx - SPLIT[11:0];

    assign main_wr_en    = cap_valid && in_main;
    assign main_wr_addr  = main_base + AW'(cap_idx);
    assign main_wr_data  = cap_data;
    assign spare_wr_en   = cap_valid && !in_main;
    assign spare_wr_addr = spare_base + AW'(spare_off);
    assign spare_wr_data = cap_data;

    AST_ONE_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_wr_en && spare_wr_en)); // R8

endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
    import nand_seq_pkg::*;
#(
    parameter int WE_LOW_CYC  = 2,
    parameter int WE_HIGH_CYC = 1,
    parameter int RE_LOW_CYC  = 2,
    parameter int RE_HIGH_CYC = 1,
    parameter int MAIN_BYTES  = 2048,
    parameter int AW          = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr_en,
    input  logic [2:0]    reg_wr_addr,
    input  logic [31:0]   reg_wr_data,
    input  logic [2:0]    reg_rd_addr,
    output logic [31:0]   reg_rd_data,
    output logic          irq,
    output logic          nand_cle,
    output logic          nand_ale,
    output logic          nand_we_n,
    output logic          nand_re_n,
    output logic [7:0]    nand_io_out,
    output logic          nand_io_oe,
    input  logic [7:0]    nand_io_in,
    input  logic          nand_rb_n,
    output logic          main_wr_en,
    output logic [AW-1:0] main_wr_addr,
    output logic [7:0]    main_wr_data,
    output logic          spare_wr_en,
    output logic [AW-1:0] spare_wr_addr,
    output logic [7:0]    spare_wr_data
);

    op_cfg_t       cfg;
    logic [31:0]   addr_lo, addr_hi;
    logic [AW-1:0] main_base, spare_base;
    logic          start, busy, done;
    logic          cap_valid;
    logic [11:0]   cap_idx;
    logic [7:0]    cap_data;

    nand_seq_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .busy       (busy),
        .done       (done),
        .cfg        (cfg),
        .addr_lo    (addr_lo),
        .addr_hi    (addr_hi),
        .main_base  (main_base),
        .spare_base (spare_base),
        .start      (start),
        .irq        (irq)
    );

    nand_seq_fsm #(
        .WE_LOW_CYC  (WE_LOW_CYC),
        .WE_HIGH_CYC (WE_HIGH_CYC),
        .RE_LOW_CYC  (RE_LOW_CYC),
        .RE_HIGH_CYC (RE_HIGH_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg       (cfg),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi),
        .rb_n      (nand_rb_n),
        .io_in     (nand_io_in),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .io_out    (nand_io_out),
        .io_oe     (nand_io_oe),
        .busy      (busy),
        .done      (done),
        .cap_valid (cap_valid),
        .cap_idx   (cap_idx),
        .cap_data  (cap_data)
    );

    nand_seq_router #(.MAIN_BYTES(MAIN_BYTES), .AW(AW)) u_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .cap_valid     (cap_valid),
        .cap_idx       (cap_idx),
        .cap_data      (cap_data),
        .main_base     (main_base),
        .spare_base    (spare_base),
        .main_wr_en    (main_wr_en),
        .main_wr_addr  (main_wr_addr),
        .main_wr_data  (main_wr_data),
        .spare_wr_en   (spare_wr_en),
        .spare_wr_addr (spare_wr_addr),
        .spare_wr_data (spare_wr_data)
    );

endmodule

// File: tb/nand_seq_top_tb.sv
module nand_seq_top_tb;

    localparam int WE_LOW = 2;
    localparam int RE_LOW = 2;
    localparam int MAINB  = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        irq;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = '0;
    logic        nand_rb_n = 1'b1;
    logic        main_wr_en, spare_wr_en;
    logic [31:0] main_wr_addr, spare_wr_addr;
    logic [7:0]  main_wr_data, spare_wr_data;

    int n_chk = 0;
    int n_bad = 0;

    // monitor state
    int          lat_n = 0;
    logic [7:0]  lat_byte [0:15];
    logic        lat_cle  [0:15];
    int          we_low = 0, re_low = 0, we_err = 0, re_err = 0;
    int          rd_n = 0, viol = 0, main_n = 0, spare_n = 0, sink_err = 0;
    logic        prev_we = 1'b1, prev_re = 1'b1;
    logic        wait_pending = 1'b0;
    logic [7:0]  salt = 8'h00;
    logic [31:0] exp_mb = '0, exp_sb = '0;

    always #2 clk = ~clk;

    nand_seq_top #(
        .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(1), .RE_LOW_CYC(RE_LOW), .RE_HIGH_CYC(1),
        .MAIN_BYTES(MAINB), .AW(32)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .irq(irq),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
        .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n),
        .main_wr_en(main_wr_en), .main_wr_addr(main_wr_addr), .main_wr_data(main_wr_data),
        .spare_wr_en(spare_wr_en), .spare_wr_addr(spare_wr_addr), .spare_wr_data(spare_wr_data)
    );

    function automatic logic [7:0] pat(input int k, input logic [7:0] s);
        return 8'(k * 7) ^ 8'(k >> 8) ^ s;
    endfunction

    function automatic logic [7:0] abyte(input int b, input logic [31:0] a1,
                                         input logic [31:0] a2);
        case (b)
            4:       return a1[15:8];
            3:       return a1[7:0];
            2:       return a2[23:16];
            1:       return a2[15:8];
            default: return a2[7:0];
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // pin monitor and flash model
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) we_low++;
            if (nand_we_n && !prev_we) begin
                if (we_low != WE_LOW) we_err++;
                if (lat_n < 16) begin
                    lat_byte[lat_n] = nand_io_out;
                    lat_cle[lat_n]  = nand_cle && !nand_ale;
                end
                if (!nand_cle && !nand_ale) we_err++;
                lat_n++;
                we_low = 0;
            end
            if (!nand_re_n) re_low++;
            if (nand_re_n && !prev_re) begin
                if (re_low != RE_LOW) re_err++;
                re_low = 0;
            end
            if (!nand_re_n && prev_re) begin
                nand_io_in <= pat(rd_n, salt);
                if (wait_pending) viol++;
                rd_n++;
            end
            if (main_wr_en) begin
                if (main_wr_addr != exp_mb + 32'(main_n) ||
                    main_wr_data != pat(main_n, salt)) sink_err++;
                main_n++;
            end
            if (spare_wr_en) begin
                if (spare_wr_addr != exp_sb + 32'(spare_n) ||
                    spare_wr_data != pat(MAINB + spare_n, salt)) sink_err++;
                spare_n++;
            end
        end
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic run_op(input logic [31:0] ctl, input logic [31:0] a1,
                          input logic [31:0] a2, input logic [31:0] mb,
                          input logic [31:0] sb, input bit inject);
        int nlat, cnt, bad, j, exp_main;
        logic [4:0] m;
        bit ie, wt;
        m   = ctl[28:24];
        ie  = ctl[30];
        wt  = ctl[15];
        cnt = int'(ctl[11:0]);
        nlat = 1 + $countones(m);
        wr(3'd1, a1); wr(3'd2, a2); wr(3'd3, mb); wr(3'd4, sb);
        exp_mb = mb; exp_sb = sb;
        salt = 8'($urandom);
        lat_n = 0; rd_n = 0; viol = 0; main_n = 0; spare_n = 0;
        sink_err = 0; we_err = 0; re_err = 0;
        wait_pending = wt;
        reg_rd_addr = 3'd0;
        wr(3'd0, ctl);
        chk(reg_rd_data[31] == 1'b1, "R3", "busy after start", reg_rd_data[31], 1);
        if (inject) begin
            wr(3'd0, 32'hC7A5_F123);
            chk(reg_rd_data[30:0] == ctl[30:0], "R10", "fields while busy",
                reg_rd_data[30:0], ctl[30:0]);
        end
        if (wt) begin
            while (lat_n < nlat) @(negedge clk);
            repeat (3 + $urandom % 6) @(negedge clk);
            nand_rb_n = 1'b0;
            repeat (3 + $urandom % 8) @(negedge clk);
            wait_pending = 1'b0;
            nand_rb_n = 1'b1;
        end
        while (reg_rd_data[31]) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(lat_n == nlat, "R5", "latch count", lat_n, nlat);
        chk(lat_cle[0] == 1'b1 && lat_byte[0] == ctl[23:16], "R4", "command latch",
            lat_byte[0], ctl[23:16]);
        chk(we_err == 0, "R4", "write pulse width/latch pins", we_err, 0);
        bad = 0; j = 1;
        for (int b = 4; b >= 0; b--) begin
            if (m[b]) begin
                if (j < 16 && (lat_cle[j] || lat_byte[j] != abyte(b, a1, a2))) bad++;
                j++;
            end
        end
        chk(bad == 0, "R5", "address byte order", bad, 0);
        chk(rd_n == cnt, (cnt == 0) ? "R9" : "R7", "read pulses", rd_n, cnt);
        chk(re_err == 0, "R7", "read pulse width", re_err, 0);
        exp_main = (cnt < MAINB) ? cnt : MAINB;
        chk(main_n == exp_main && spare_n == cnt - exp_main, "R8", "sink split",
            main_n * 65536 + spare_n, exp_main * 65536 + (cnt - exp_main));
        chk(sink_err == 0, "R8", "sink address/data", sink_err, 0);
        if (wt) chk(viol == 0, "R6", "read before ready", viol, 0);
        chk(irq == (ie && !inject), "R11", "irq at end", irq, ie && !inject);
        if (irq) begin
            repeat (5) @(negedge clk);
            chk(irq == 1'b1, "R11", "irq sticky", irq, 1);
            wr(3'd0, 32'h0000_0000);
            chk(irq == 1'b0, "R11", "irq cleared by write", irq, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ctl, a1, a2;
        int sel, cnt;
        void'($urandom(32'h0BAD_5EED));
        repeat (5) @(negedge clk);
        chk(!nand_cle && !nand_ale && nand_we_n && nand_re_n && !nand_io_oe, "R1",
            "pins in reset", {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe}, 5'b00110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(reg_rd_data[31] == 1'b0 && irq == 1'b0, "R1", "busy/irq after reset",
            {reg_rd_data[31], irq}, 0);

        // R12 and R2: fields load without starting
        lat_n = 0;
        wr(3'd0, 32'h5E3C_A00A);
        repeat (10) @(negedge clk);
        chk(reg_rd_data == 32'h5E3C_A00A && lat_n == 0, "R12", "no start, fields",
            reg_rd_data, 32'h5E3C_A00A);
        wr(3'd2, 32'hDEAD_BEEF);
        reg_rd_addr = 3'd2;
        #1;
        chk(reg_rd_data == 32'hDEAD_BEEF, "R2", "high address readback",
            reg_rd_data, 32'hDEAD_BEEF);
        reg_rd_addr = 3'd0;

        // full mask, command only, no data (R9)
        run_op(32'h9F00_0000, 32'h0000_12AB, 32'h3344_5566, 32'h1000, 32'h9000, 1'b0);
        // reset-style command with wait, no data (R6, R9)
        run_op(32'hC0FF_8000, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0);
        // full page read with wait and irq (R8 boundary)
        run_op(32'hC030_8840, 32'h0000_0102, 32'h0304_0506, 32'h0002_0000,
               32'h0003_0000, 1'b0);
        // start while busy ignored (R10)
        run_op(32'h9100_0028, 32'h0000_0077, 32'h0000_0088, 32'h400, 32'h800, 1'b1);

        for (int i = 0; i < 12; i++) begin
            sel = int'($urandom % 3);
            if (sel == 0)      cnt = 0;
            else if (sel == 1) cnt = 1 + int'($urandom % 24);
            else               cnt = 12'h7F8 + int'($urandom % 20);
            ctl = 32'h8000_0000 | ({31'b0, 1'($urandom)} << 30) |
                  ({27'b0, 5'($urandom)} << 24) | ({24'b0, 8'($urandom)} << 16) |
                  ({31'b0, 1'($urandom)} << 15) | 32'(cnt);
            a1 = $urandom; a2 = $urandom;
            run_op(ctl, a1, a2, $urandom & 32'h00FF_FFFF, $urandom & 32'h00FF_FFFF, 1'b0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule